// File: doc/BRIEF.md
# DMA Control-Port Decoder

This block is the control side of a four-channel DMA controller. It watches byte reads and writes on a small register window. Writes to offsets 8 to 15 become controller actions: loading the command byte, changing a request bit, changing the mask, storing a channel mode, clearing the byte-pointer flip-flop and doing a master reset. Reads return the status byte or the mask. Any access to offsets 0 to 7 belongs to the per-channel address and count registers, which live elsewhere. For those accesses this block only toggles the shared byte-pointer flip-flop.

Peripherals raise or drop their request line for each channel through hold and release inputs. The transfer engine reports the end of a block through terminal-count inputs. The block combines the mask and the request bits into a service enable for each channel. It also picks one enabled channel by fixed priority. Data movement is not part of this block.

Top module: `dmactl_top`

## Requirements
- R1: After reset all mask bits are 1, and command, status, all four mode bytes and the flip-flop are 0. No channel is enabled and no grant is given.
- R2: A write at offset 8 loads the command byte only when the value has no set bit other than bit 2 (so 0x00 and 0x04 are accepted). Any other value leaves the command byte unchanged.
- R3: A write at offset 9 picks channel wdata[1:0]. It sets that channel's request bit (status bit channel+4) when wdata[2] is 1 and clears it when wdata[2] is 0. It always clears that channel's terminal-count bit (status bit channel).
- R4: A write at offset 10 sets the mask bit of channel wdata[1:0] when wdata[2] is 1 and clears it when wdata[2] is 0. The other mask bits are unchanged.
- R5: A write at offset 11 stores the whole write byte as the mode of channel wdata[1:0]. That is mode_o[8c+7:8c] for channel c. The other modes are unchanged.
- R6: A write at offset 12 clears the flip-flop. Any read or write at offsets 0 to 7 inverts it once. Other control accesses leave it unchanged.
- R7: A write at offset 13 clears the flip-flop, status and command and sets all mask bits. The modes are left as they were.
- R8: A write at offset 14 clears all mask bits. A write at offset 15 loads mask bit c from wdata[c].
- R9: A read at offset 8 returns {request[3:0], terminal-count[3:0]} in the same cycle and clears the terminal-count bits at the next clock edge. A read at offset 15 returns {4'b0000, mask}. Every other offset reads as 0.
- R10: dreq_hold_i[c] sets request bit c and dreq_release_i[c] clears it. When both are high, hold wins. Both take precedence over an offset 9 or offset 13 write in the same cycle.
- R11: tc_i[c] sets terminal-count bit c. A terminal count that arrives in the same cycle as a status read is kept, not lost.
- R12: svc_en_o[c] is 1 exactly when mask bit c is 0 and request bit c is 1. grant_o is one-hot on the lowest-numbered enabled channel. grant_valid_o is 1 when any channel is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Byte write strobe |
| rd_en_i | input | 1 | Byte read strobe |
| addr_i | input | 4 | Register offset 0 to 15 |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for control offsets, 0 otherwise |
| dreq_hold_i | input | 4 | Per-channel request raise |
| dreq_release_i | input | 4 | Per-channel request drop |
| tc_i | input | 4 | Per-channel terminal-count report |
| cmd_o | output | 8 | Accepted command byte |
| mode_o | output | 32 | Four mode bytes, channel c at [8c+7:8c] |
| mask_o | output | 4 | Channel mask bits |
| flip_o | output | 1 | Byte-pointer flip-flop, 1 selects the high byte |
| svc_en_o | output | 4 | Per-channel service enable |
| grant_o | output | 4 | One-hot chosen channel |
| grant_valid_o | output | 1 | Some channel is enabled |

## Verification
The command filter gets the accepted values 0x00 and 0x04 and the rejected values 0x05 and 0x10. This shows whether the filter keys on bit 2 alone or on the whole byte. The request and mask paths are driven with set and clear patterns on several channels. These show that only the addressed bit moves and that an offset 9 write clears exactly one terminal-count bit. Device inputs and terminal counts are made to collide with bus writes and status reads in the same cycle, which fixes which source wins. The priority grant is tried with two enabled channels before and after masking the winner, to check that the choice moves to the next channel.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

    // Control actions, indexed by the low three offset bits of offsets 8..15.
    typedef enum logic [2:0] {
        OP_CMD      = 3'd0,
        OP_REQ      = 3'd1,
        OP_MASK_ONE = 3'd2,
        OP_MODE     = 3'd3,
        OP_CLR_FF   = 3'd4,
        OP_MRESET   = 3'd5,
        OP_MASK_CLR = 3'd6,
        OP_MASK_LD  = 3'd7
    } ctl_op_e;

    localparam int OFS_W = 4;
    // Only this command bit may be set for a command write to be taken.
    localparam logic [7:0] CMD_ALLOWED = 8'h04;

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
    import dmactl_pkg::*;
(
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [OFS_W-1:0] addr_i,
    output logic             wr_ctl_o,
    output logic             rd_ctl_o,
    output logic             chan_acc_o,
    output ctl_op_e          op_o
);
    logic ctl_window;

    always_comb begin
        ctl_window = addr_i[OFS_W-1];
        wr_ctl_o   = wr_en_i && ctl_window;
        rd_ctl_o   = rd_en_i && ctl_window;
        chan_acc_o = (wr_en_i || rd_en_i) && !ctl_window;
        op_o       = ctl_op_e'(addr_i[2:0]);
    end
endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl_i,
    input  logic              rd_ctl_i,
    input  logic              chan_acc_i,
    input  ctl_op_e           op_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NCH-1:0]    dreq_hold_i,
    input  logic [NCH-1:0]    dreq_release_i,
    input  logic [NCH-1:0]    tc_i,
    output logic [DW-1:0]     rdata_o,
    output logic [DW-1:0]     cmd_o,
    output logic [NCH*DW-1:0] mode_o,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    req_o,
    output logic              flip_o
);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [DW-1:0]           cmd;
        logic [NCH-1:0]          mask;
        logic [NCH-1:0]          req;
        logic [NCH-1:0]          tc;
        logic                    flip;
        logic [NCH-1:0][DW-1:0]  mode;
    } regs_t;

    regs_t st_d, st_q;
    logic [CHW-1:0] sel;

    always_comb begin
        sel  = wdata_i[CHW-1:0];
        st_d = st_q;
        // A status read drops the terminal-count bits at this edge.
        if (rd_ctl_i && op_i == OP_CMD) begin
            st_d.tc = '0;
        end
        if (chan_acc_i) begin
            st_d.flip = ~st_q.flip;
        end
        if (wr_ctl_i) begin
            unique case (op_i)
                OP_CMD: begin
                    if ((wdata_i & ~CMD_ALLOWED) == '0) begin
                        st_d.cmd = wdata_i;
                    end
                end
                OP_REQ: begin
                    st_d.req[sel] = wdata_i[2];
                    st_d.tc[sel]  = 1'b0;
                end
                OP_MASK_ONE: st_d.mask[sel] = wdata_i[2];
                OP_MODE:     st_d.mode[sel] = wdata_i;
                OP_CLR_FF:   st_d.flip = 1'b0;
                OP_MRESET: begin
                    st_d.flip = 1'b0;
                    st_d.mask = '1;
                    st_d.req  = '0;
                    st_d.tc   = '0;
                    st_d.cmd  = '0;
                end
                OP_MASK_CLR: st_d.mask = '0;
                OP_MASK_LD:  st_d.mask = wdata_i[NCH-1:0];
                default: ;
            endcase
        end
        // Device request lines override bus writes; hold beats release.
        st_d.req = (st_d.req & ~dreq_release_i) | dreq_hold_i;
        st_d.tc  = st_d.tc | tc_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd_ctl_i) begin
            if (op_i == OP_CMD) begin
                rdata_o = DW'({st_q.req, st_q.tc});
            end else if (op_i == OP_MASK_LD) begin
                rdata_o = DW'(st_q.mask);
            end
        end
    end

    assign cmd_o  = st_q.cmd;
    assign mode_o = st_q.mode;
    assign mask_o = st_q.mask;
    assign req_o  = st_q.req;
    assign flip_o = st_q.flip;

    // R2: only the permitted command bit can ever be held
    a_r2_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cmd & ~CMD_ALLOWED) == '0);

    // R7: master reset leaves mask full, command empty, flip-flop low
    a_r7_master_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl_i && op_i == OP_MRESET) |=>
            (st_q.mask == '1 && st_q.cmd == '0 && !st_q.flip));

    // R9: status read without a new terminal count empties the low nibble
    a_r9_read_clears_tc: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl_i && op_i == OP_CMD && tc_i == '0) |=> (st_q.tc == '0));

    // R10: a held request line always shows up as a set request bit
    a_r10_hold_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|dreq_hold_i) |=> ((st_q.req & $past(dreq_hold_i)) == $past(dreq_hold_i)));

    // R6: a channel register access flips the byte pointer
    a_r6_ff_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        chan_acc_i |=> (st_q.flip != $past(st_q.flip)));

    // R11: a reported terminal count is never lost
    a_r11_tc_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (|tc_i) |=> ((st_q.tc & $past(tc_i)) == $past(tc_i)));
endmodule

// File: rtl/dmactl_service.sv
module dmactl_service #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] mask_i,
    input  logic [NCH-1:0] req_i,
    output logic [NCH-1:0] svc_en_o,
    output logic [NCH-1:0] grant_o,
    output logic           grant_valid_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_en
        assign svc_en_o[c] = !mask_i[c] && req_i[c];
    end

    logic found;
    always_comb begin
        grant_o = '0;
        found   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (svc_en_o[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign grant_valid_o = |grant_o;

    // R12: at most one channel granted
    a_r12_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R12: a grant only goes to an enabled channel
    a_r12_grant_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~svc_en_o) == '0);

    // R12: some channel is granted whenever any is enabled
    a_r12_grant_when_any: assert property (@(posedge clk) disable iff (!rst_n)
        (|svc_en_o) == grant_valid_o);
endmodule

// File: rtl/dmactl_top.sv
module dmactl_top
    import dmactl_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [OFS_W-1:0]  addr_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    input  logic [NCH-1:0]    dreq_hold_i,
    input  logic [NCH-1:0]    dreq_release_i,
    input  logic [NCH-1:0]    tc_i,
    output logic [DW-1:0]     cmd_o,
    output logic [NCH*DW-1:0] mode_o,
    output logic [NCH-1:0]    mask_o,
    output logic              flip_o,
    output logic [NCH-1:0]    svc_en_o,
    output logic [NCH-1:0]    grant_o,
    output logic              grant_valid_o
);
    logic     wr_ctl, rd_ctl, chan_acc;
    ctl_op_e  op;
    logic [NCH-1:0] req;

    dmactl_decode u_decode (
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .wr_ctl_o   (wr_ctl),
        .rd_ctl_o   (rd_ctl),
        .chan_acc_o (chan_acc),
        .op_o       (op)
    );

    dmactl_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_ctl_i       (wr_ctl),
        .rd_ctl_i       (rd_ctl),
        .chan_acc_i     (chan_acc),
        .op_i           (op),
        .wdata_i        (wdata_i),
        .dreq_hold_i    (dreq_hold_i),
        .dreq_release_i (dreq_release_i),
        .tc_i           (tc_i),
        .rdata_o        (rdata_o),
        .cmd_o          (cmd_o),
        .mode_o         (mode_o),
        .mask_o         (mask_o),
        .req_o          (req),
        .flip_o         (flip_o)
    );

    dmactl_service #(.NCH(NCH)) u_service (
        .clk           (clk),
        .rst_n         (rst_n),
        .mask_i        (mask_o),
        .req_i         (req),
        .svc_en_o      (svc_en_o),
        .grant_o       (grant_o),
        .grant_valid_o (grant_valid_o)
    );
endmodule

// File: tb/tb_dmactl_top.sv
module tb_dmactl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [3:0]  hold = '0, rel = '0, tc = '0;
    logic [7:0]  cmd;
    logic [31:0] mode;
    logic [3:0]  mask, svc, grant;
    logic        flip, gvalid;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    dmactl_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .dreq_hold_i(hold), .dreq_release_i(rel), .tc_i(tc),
        .cmd_o(cmd), .mode_o(mode), .mask_o(mask), .flip_o(flip),
        .svc_en_o(svc), .grant_o(grant), .grant_valid_o(gvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] h, input logic [3:0] r, input logic [3:0] t);
        @(negedge clk);
        hold = h; rel = r; tc = t;
        @(negedge clk);
        hold = '0; rel = '0; tc = '0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        chk("R1 mask", mask, 4'hF);
        chk("R1 cmd", cmd, 8'h00);
        chk("R1 mode", mode, 32'h0);
        chk("R1 flip", flip, 1'b0);
        chk("R1 svc", {svc, grant, gvalid}, 9'h0);
        do_rd(4'd8, v);
        chk("R1 status", v, 8'h00);
    endtask

    task automatic t_command();
        do_wr(4'd8, 8'h04); chk("R2 accept 04", cmd, 8'h04);
        do_wr(4'd8, 8'h05); chk("R2 reject 05", cmd, 8'h04);
        do_wr(4'd8, 8'h00); chk("R2 accept 00", cmd, 8'h00);
        do_wr(4'd8, 8'h10); chk("R2 reject 10", cmd, 8'h00);
    endtask

    task automatic t_request();
        logic [7:0] v;
        do_wr(4'd13, 8'h00);
        pulse(4'h0, 4'h0, 4'b0011);
        do_wr(4'd9, 8'h06);
        do_wr(4'd9, 8'h05);
        do_rd(4'd8, v); chk("R3 set req, clear tc1", v, 8'h61);
        do_rd(4'd8, v); chk("R9 tc cleared by read", v, 8'h60);
        do_wr(4'd9, 8'h02);
        do_rd(4'd8, v); chk("R3 clear req ch2", v, 8'h20);
        chk("R12 masked no svc", svc, 4'h0);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        do_wr(4'd13, 8'h00);
        do_wr(4'd10, 8'h00); chk("R4 clear ch0", mask, 4'b1110);
        do_wr(4'd10, 8'h04); chk("R4 set ch0", mask, 4'b1111);
        do_wr(4'd10, 8'h03); chk("R4 clear ch3", mask, 4'b0111);
        do_rd(4'd15, v);     chk("R9 mask read", v, 8'h07);
        do_wr(4'd14, 8'hFF); chk("R8 clear all", mask, 4'h0);
        do_wr(4'd15, 8'h0A); chk("R8 load", mask, 4'hA);
        do_rd(4'd15, v);     chk("R9 mask read 2", v, 8'h0A);
        do_rd(4'd10, v);     chk("R9 other offset 10", v, 8'h00);
        do_rd(4'd13, v);     chk("R9 other offset 13", v, 8'h00);
        chk("R9 read 13 no reset", mask, 4'hA);
    endtask

    task automatic t_mode();
        do_wr(4'd11, 8'h96); chk("R5 mode ch2", mode, 32'h0096_0000);
        do_wr(4'd11, 8'h5B); chk("R5 mode ch3", mode, 32'h5B96_0000);
    endtask

    task automatic t_flipflop();
        logic [7:0] v;
        do_wr(4'd13, 8'h00);
        do_wr(4'd0, 8'h12); chk("R6 toggle on write", flip, 1'b1);
        do_rd(4'd3, v);     chk("R6 toggle on read", flip, 1'b0);
        chk("R9 chan offset reads 0", v, 8'h00);
        do_wr(4'd5, 8'h00); chk("R6 toggle again", flip, 1'b1);
        do_rd(4'd8, v);     chk("R6 control read no toggle", flip, 1'b1);
        do_wr(4'd12, 8'h00); chk("R6 clear", flip, 1'b0);
    endtask

    task automatic t_master_reset();
        logic [7:0] v;
        do_wr(4'd8, 8'h04);
        do_wr(4'd14, 8'h00);
        do_wr(4'd7, 8'h00);
        pulse(4'b0110, 4'h0, 4'b1001);
        do_wr(4'd13, 8'h00);
        chk("R7 mask", mask, 4'hF);
        chk("R7 cmd", cmd, 8'h00);
        chk("R7 flip", flip, 1'b0);
        chk("R7 modes kept", mode, 32'h5B96_0000);
        do_rd(4'd8, v);
        chk("R7 status", v, 8'h00);
    endtask

    task automatic t_dreq();
        logic [7:0] v;
        do_wr(4'd13, 8'h00);
        pulse(4'b0101, 4'h0, 4'h0);
        do_rd(4'd8, v); chk("R10 hold", v, 8'h50);
        pulse(4'h0, 4'b0001, 4'h0);
        do_rd(4'd8, v); chk("R10 release", v, 8'h40);
        pulse(4'b0010, 4'b0010, 4'h0);
        do_rd(4'd8, v); chk("R10 hold beats release", v, 8'h60);
        @(negedge clk);
        addr = 4'd9; wdata = 8'h01; wr_en = 1'b1; hold = 4'b0010;
        @(negedge clk);
        wr_en = 1'b0; hold = '0;
        do_rd(4'd8, v); chk("R10 hold beats bus clear", v, 8'h60);
        @(negedge clk);
        addr = 4'd9; wdata = 8'h06; wr_en = 1'b1; rel = 4'b0100;
        @(negedge clk);
        wr_en = 1'b0; rel = '0;
        do_rd(4'd8, v); chk("R10 release beats bus set", v, 8'h20);
    endtask

    task automatic t_tc_read();
        logic [7:0] v;
        do_wr(4'd13, 8'h00);
        pulse(4'h0, 4'h0, 4'b0100);
        @(negedge clk);
        addr = 4'd8; rd_en = 1'b1; tc = 4'b0001;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0; tc = '0;
        chk("R11 read returns old tc", v, 8'h04);
        do_rd(4'd8, v); chk("R11 new tc kept", v, 8'h01);
        do_rd(4'd8, v); chk("R9 tc gone", v, 8'h00);
    endtask

    task automatic t_priority();
        do_wr(4'd13, 8'h00);
        do_wr(4'd14, 8'h00);
        pulse(4'b1100, 4'h0, 4'h0);
        chk("R12 svc", svc, 4'b1100);
        chk("R12 grant low", {gvalid, grant}, 5'b1_0100);
        do_wr(4'd10, 8'h06);
        chk("R12 svc masked", svc, 4'b1000);
        chk("R12 grant moves", {gvalid, grant}, 5'b1_1000);
        pulse(4'h0, 4'b1000, 4'h0);
        chk("R12 none", {svc, gvalid, grant}, 9'h0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_command();
        t_request();
        t_mask();
        t_mode();
        t_flipflop();
        t_master_reset();
        t_dreq();
        t_tc_read();
        t_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule